// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block steps through one successive-approximation conversion of a configurable width, 16 bits by default. The analog side sits outside the block and is reached through three signals. A trial code goes out to a DAC. A hold line freezes the sample/hold. A single comparator bit comes back, high when the held input is at or above the current trial level.

A conversion request is the falling edge of the OR of an active-low select and a read/convert line. When a request arrives, the block enters hold and lowers its busy output. It then settles one bit per clock, starting at the most significant bit. On the last bit it writes the finished code into the result register and raises busy in the same clock edge.

While power-down is asserted, no new conversion can start. If both request lines are still low when busy rises, a second conversion starts immediately, with no time left for acquisition. A programmable acquisition counter flags any start that comes too soon after the previous result, including such a re-trigger.

Top module: `sar_conv_seq`

## Requirements
- R1: During and directly after synchronous reset, busy_n is 1, hold is 0, trial is 0, result is 0 and early_start is 0.
- R2: When the block is idle and power-down is low, a clock edge that samples cs_n|rd_cnv as 0 starts a conversion if the previous edge sampled that OR as 1. busy_n is 0 right after that edge.
- R3: The request is qualified only by the OR. A fall of cs_n while rd_cnv is high starts nothing, and neither does a fall of rd_cnv while cs_n is high. A fall of cs_n while rd_cnv is already low does start a conversion.
- R4: The first trial code after a start has only the top bit set (0x8000 at the default width). Each later edge settles the current bit and moves to the next lower one. A bit is kept at 1 when cmp_ge is 1 and is cleared otherwise.
- R5: With an ideal comparator (cmp_ge = held input >= trial), result equals the held input code. result is loaded on the same edge at which busy_n rises. busy_n stays low for exactly RES_W clock cycles.
- R6: hold is 1 exactly while busy_n is 0, so changes to the analog input during a conversion do not affect the result.
- R7: Request edges that arrive while a conversion is in progress are ignored. They do not start a conversion after the current one finishes.
- R8: If cs_n|rd_cnv is still 0 on the first edge after busy_n rises, and power-down is low, a new conversion starts on that edge. early_start is then 1 whenever acq_cycles is nonzero.
- R9: While pwr_dn is 1, no conversion starts and result keeps its value.
- R10: A start sampled within acq_cycles edges after the edge that raised busy_n sets early_start to 1. A later start clears it. early_start holds its value until the next start.
- R11: busy_n is never low for more than RES_W consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencing clock, one bit settled per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select, ORed with rd_cnv |
| rd_cnv | input | 1 | Read/convert line; low half of the request |
| pwr_dn | input | 1 | High blocks new conversions |
| acq_cycles | input | ACQ_W (8) | Minimum acquisition window in cycles |
| cmp_ge | input | 1 | Comparator: held input >= trial |
| trial | output | RES_W (16) | Trial code to the DAC |
| hold | output | 1 | Sample/hold control, 1 = hold |
| busy_n | output | 1 | Low while a conversion runs |
| result | output | RES_W (16) | Last completed conversion code |
| early_start | output | 1 | Last start came before the acquisition window ended |

## Verification
The properties assume three things about the inputs. cmp_ge is a function of the current trial code and a held value that stays fixed while hold is 1. acq_cycles does not change while a start is being evaluated. pwr_dn does not reach back into a conversion that is already running. The bench meets these assumptions with an ideal comparator that captures its input code only while hold is 0. It changes request lines, power-down and the analog value only on falling clock edges, and it keeps acq_cycles at one fixed value, so every start is seen on a single known edge.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_CONV = 1'b1
    } sar_phase_e;

    function automatic int idx_bits(input int width);
        return (width > 1) ? $clog2(width) : 1;
    endfunction

endpackage

// File: rtl/sar_start_qual.sv
module sar_start_qual (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic rd_cnv,
    input  logic pwr_dn,
    input  logic idle,
    input  logic just_done,
    output logic start
);
    logic req_now;
    logic req_q;

    assign req_now = cs_n | rd_cnv;

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b1;
        else     req_q <= req_now;
    end

    // fresh falling edge, or request still low right after completion
    assign start = idle && !pwr_dn && !req_now && (req_q || just_done);

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine
    import sar_seq_pkg::*;
#(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cmp_ge,
    output logic [RES_W-1:0] trial,
    output logic [RES_W-1:0] done_code,
    output logic             done,
    output logic             idle,
    output logic             busy_n
);
    localparam int IDX_W = idx_bits(RES_W);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);

    sar_phase_e       phase;
    logic [IDX_W-1:0] idx;
    logic [RES_W-1:0] code;
    logic [RES_W-1:0] mask;

    assign mask      = {{(RES_W-1){1'b0}}, 1'b1} << idx;
    assign trial     = (phase == PH_CONV) ? (code | mask) : code;
    assign done_code = cmp_ge ? (code | mask) : code;
    assign done      = (phase == PH_CONV) && (idx == '0);
    assign idle      = (phase == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            idx    <= '0;
            code   <= '0;
            busy_n <= 1'b1;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase  <= PH_CONV;
                        idx    <= TOP_IDX;
                        code   <= '0;
                        busy_n <= 1'b0;
                    end
                end
                PH_CONV: begin
                    code <= done_code;
                    if (idx == '0) begin
                        phase  <= PH_IDLE;
                        busy_n <= 1'b1;
                    end else begin
                        idx <= idx - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sar_acq_timer.sv
module sar_acq_timer #(
    parameter int ACQ_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done,
    input  logic [ACQ_W-1:0] acq_cycles,
    output logic             early
);
    logic [ACQ_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)              remain <= '0;
        else if (done)        remain <= acq_cycles;
        else if (remain != 0) remain <= remain - 1'b1;
    end

    assign early = (remain != '0);

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
    parameter int RES_W = 16,
    parameter int ACQ_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             rd_cnv,
    input  logic             pwr_dn,
    input  logic [ACQ_W-1:0] acq_cycles,
    input  logic             cmp_ge,
    output logic [RES_W-1:0] trial,
    output logic             hold,
    output logic             busy_n,
    output logic [RES_W-1:0] result,
    output logic             early_start
);
    logic             start;
    logic             done;
    logic             idle;
    logic             just_done;
    logic             early;
    logic [RES_W-1:0] done_code;

    sar_start_qual u_qual (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .rd_cnv    (rd_cnv),
        .pwr_dn    (pwr_dn),
        .idle      (idle),
        .just_done (just_done),
        .start     (start)
    );

    sar_bit_engine #(.RES_W(RES_W)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmp_ge    (cmp_ge),
        .trial     (trial),
        .done_code (done_code),
        .done      (done),
        .idle      (idle),
        .busy_n    (busy_n)
    );

    sar_acq_timer #(.ACQ_W(ACQ_W)) u_acq (
        .clk        (clk),
        .rst        (rst),
        .done       (done),
        .acq_cycles (acq_cycles),
        .early      (early)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold        <= 1'b0;
            result      <= '0;
            early_start <= 1'b0;
            just_done   <= 1'b0;
        end else begin
            just_done <= done;
            if (start) begin
                hold        <= 1'b1;
                early_start <= early;
            end else if (done) begin
                hold <= 1'b0;
            end
            if (done) result <= done_code;
        end
    end

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int RES_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             rd_cnv,
    input logic             pwr_dn,
    input logic [RES_W-1:0] trial,
    input logic             hold,
    input logic             busy_n,
    input logic [RES_W-1:0] result
);
    localparam int CNT_W = $clog2(RES_W + 2);
    localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

    logic [CNT_W-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)                             low_run <= '0;
        else if (busy_n)                     low_run <= '0;
        else if (low_run <= CNT_W'(RES_W))   low_run <= low_run + 1'b1;
    end

    p_hold_busy_r6: assert property (@(posedge clk) disable iff (rst)
        hold == !busy_n);

    p_conv_bound_r11: assert property (@(posedge clk) disable iff (rst)
        low_run <= CNT_W'(RES_W));

    p_first_trial_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_n) |-> trial == MSB_ONLY);

    p_pd_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        (pwr_dn && busy_n) |=> busy_n);

    p_result_kept_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_n && $past(busy_n)) |-> $stable(result));

    p_retrigger_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy_n) && !(cs_n | rd_cnv) && !pwr_dn) |=> !busy_n);

endmodule

bind sar_conv_seq sar_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .rd_cnv (rd_cnv),
    .pwr_dn (pwr_dn),
    .trial  (trial),
    .hold   (hold),
    .busy_n (busy_n),
    .result (result)
);

// File: tb/sim_sar_conv_seq.sv
`timescale 1ns/1ps
module sim_sar_conv_seq;
    localparam int RES_W = 16;
    localparam int ACQ_W = 8;
    localparam int ACQ   = 4;

    logic             clk = 1'b0;
    logic             rst;
    logic             cs_n, rd_cnv, pwr_dn;
    logic [ACQ_W-1:0] acq_cycles;
    logic             cmp_ge;
    logic [RES_W-1:0] trial, result;
    logic             hold, busy_n, early_start;

    logic [RES_W-1:0] ain;
    logic [RES_W-1:0] held;
    logic [RES_W-1:0] exp_q[$];
    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    sar_conv_seq #(.RES_W(RES_W), .ACQ_W(ACQ_W)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_cnv(rd_cnv), .pwr_dn(pwr_dn),
        .acq_cycles(acq_cycles), .cmp_ge(cmp_ge), .trial(trial), .hold(hold),
        .busy_n(busy_n), .result(result), .early_start(early_start)
    );

    // ideal analog model: track while sampling, freeze in hold
    always @(posedge clk) if (!hold) held <= ain;
    assign cmp_ge = (held >= trial);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor / scoreboard
    bit prev_b = 1'b1;
    int low_cnt = 0;
    always @(negedge clk) begin
        if (rst) begin
            prev_b  = 1'b1;
            low_cnt = 0;
        end else begin
            if (!busy_n) low_cnt++;
            if (busy_n && !prev_b) begin
                chk("R5 busy low cycles", low_cnt, RES_W);
                if (exp_q.size() == 0) begin
                    chk("R7 unexpected conversion", 1, 0);
                end else begin
                    chk("R5 result", result, exp_q.pop_front());
                end
                low_cnt = 0;
            end
            prev_b = busy_n;
        end
    end

    task automatic kick_rd(input logic [RES_W-1:0] code);
        @(negedge clk);
        ain = code; cs_n = 1'b0; rd_cnv = 1'b0;
        exp_q.push_back(code);
        @(negedge clk);
        rd_cnv = 1'b1;
        chk("R2 busy low after start", busy_n, 0);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!busy_n);
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [RES_W-1:0] codes [4] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h0001};
        logic [RES_W-1:0] last;
        bit saw_low;
        rst = 1'b1; cs_n = 1'b1; rd_cnv = 1'b1; pwr_dn = 1'b0;
        acq_cycles = ACQ_W'(ACQ); ain = '0;
        gap(3);
        chk("R1 busy_n", busy_n, 1);
        chk("R1 hold", hold, 0);
        chk("R1 trial", trial, 0);
        chk("R1 result", result, 0);
        chk("R1 early_start", early_start, 0);
        rst = 1'b0;
        gap(2);
        chk("R1 busy_n after release", busy_n, 1);

        // R2 R4 R6: main conversion, input moved during hold
        kick_rd(16'hA5C3);
        chk("R4 first trial", trial, 16'h8000);
        chk("R6 hold during conversion", hold, 1);
        @(negedge clk);
        chk("R4 second trial", trial, 16'hC000);
        ain = 16'h1234;
        wait_idle();
        chk("R6 hold released", hold, 0);
        chk("R6 result ignores moved input", result, 16'hA5C3);

        // R10 clean starts across edge codes
        foreach (codes[i]) begin
            gap(8);
            kick_rd(codes[i]);
            chk("R10 late start not flagged", early_start, 0);
            wait_idle();
        end

        // R10 early start
        kick_rd(16'h5A5A);
        chk("R10 early start flagged", early_start, 1);
        wait_idle();

        // R3 OR qualification
        gap(8);
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk); rd_cnv = 1'b0;
        gap(3);
        chk("R3 rd fall with cs high ignored", busy_n, 1);
        @(negedge clk); ain = 16'h7FFF; cs_n = 1'b0; exp_q.push_back(16'h7FFF);
        @(negedge clk);
        chk("R3 cs fall with rd low starts", busy_n, 0);
        rd_cnv = 1'b1;
        wait_idle();
        gap(6);
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk); cs_n = 1'b0;
        gap(3);
        chk("R3 cs fall with rd high ignored", busy_n, 1);

        // R7 edge during conversion ignored
        gap(4);
        kick_rd(16'h0F0F);
        @(negedge clk); rd_cnv = 1'b0;
        @(negedge clk); rd_cnv = 1'b1;
        wait_idle();
        saw_low = 0;
        repeat (6) begin
            @(negedge clk);
            if (!busy_n) saw_low = 1;
        end
        chk("R7 no start after ignored edge", saw_low, 0);

        // R8 re-trigger with request held low
        @(negedge clk); ain = 16'h3C3C; rd_cnv = 1'b0;
        exp_q.push_back(16'h3C3C);
        exp_q.push_back(16'hC3C3);
        @(negedge clk); ain = 16'hC3C3;
        wait_idle();
        @(negedge clk);
        chk("R8 retrigger busy", busy_n, 0);
        chk("R8 retrigger flagged", early_start, 1);
        rd_cnv = 1'b1;
        wait_idle();

        // R9 power-down blocks starts
        gap(8);
        last = result;
        pwr_dn = 1'b1;
        @(negedge clk); ain = 16'hBEEF; rd_cnv = 1'b0;
        gap(4);
        chk("R9 no start in power-down", busy_n, 1);
        chk("R9 result kept", result, last);
        @(negedge clk); rd_cnv = 1'b1; pwr_dn = 1'b0;
        kick_rd(16'hBEEF);
        wait_idle();

        gap(3);
        chk("R5 scoreboard drained", exp_q.size(), 0);
        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule